// File: doc/BRIEF.md
# Partial-Register Stall Controller

This block sits in the rename stage of an out-of-order core. It records, for every architectural register, which narrow parts (low byte, high byte, low 16 bits) hold a write that has not yet retired. Each cycle it looks at one instruction, which carries an optional destination and an optional source. It raises `stall` when the source read needs bits that a pending narrow write does not fully supply, so the rename stage must not hand out a single physical register for that read yet.

The stall can end in one of two ways, chosen by `mergeMode`. In retire-wait mode the stall holds until a retire pulse arrives for the register. In merge mode the block charges a fixed merge penalty instead, with one extra cycle when a pending high-byte part takes part in the hazard. A register that was zeroed by a full-width zeroing idiom is known to hold zero above any later narrow write, so reads of it never stall.

Top module: `partial_reg_stall`

## Requirements
- R1: After reset, `stall` is low, and a 64-bit read of any register does not stall.
- R2: Width codes are 0 = bits 7:0, 1 = bits 15:8, 2 = bits 15:0, 3 = 32-bit, 4 = 64-bit (5 to 7 act as 64-bit). A read that overlaps a pending narrow part but also needs bits outside it raises `stall` in the same cycle. Examples: a 16-bit or wider read after a low-byte write, or a 64-bit read after a 16-bit write.
- R3: A read that lies inside a pending part, or that does not overlap it, does not stall. Examples: a low-byte read after a 16-bit write, or a high-byte read after a low-byte write. The low and high bytes are tracked as separate parts.
- R4: In retire-wait mode (`mergeMode`=0) the stall holds for as long as the instruction is held. A retire pulse for another register has no effect. A retire pulse for the register clears all its pending parts at the clock edge, and `stall` is low from the next cycle. While `stall` is high the upstream stage keeps the instruction unchanged.
- R5: A full-width destination (32 or 64 bit) written with `zeroIdiom`=1 marks the register known-clear. Later reads of that register do not stall, even after narrow writes to it. `zeroIdiom` has no effect on narrow destinations.
- R6: A full-width write without `zeroIdiom` removes the known-clear mark, so hazards are detected on that register again.
- R7: Any accepted 32- or 64-bit write clears every pending part of its register.
- R8: In merge mode, a hazard that involves only low-byte or 16-bit pending parts stalls for exactly `MERGE_CYCLES` (default 2) cycles. The merge then clears the register's pending parts, so the same read that follows does not stall.
- R9: In merge mode, a hazard that involves a pending high-byte part stalls for `MERGE_CYCLES + HIGH_EXTRA` (default 3) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mergeMode | input | 1 | 1 = fixed merge penalty, 0 = wait for retirement |
| dstEn | input | 1 | Instruction writes a destination |
| dstIdx | input | IDX_W | Destination register index |
| dstWidth | input | 3 | Destination width code |
| zeroIdiom | input | 1 | Destination write is a self-XOR/SUB zeroing idiom |
| srcEn | input | 1 | Instruction reads a source |
| srcIdx | input | IDX_W | Source register index |
| srcWidth | input | 3 | Source read width code |
| retireValid | input | 1 | A narrow write retires this cycle |
| retireIdx | input | IDX_W | Register whose pending parts the retirement clears |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
`stall` is combinational from the registered state and the presented instruction, so it is sampled 2 ns after the falling edge that drives the instruction. Writes, retirements and merge completions change state at the next rising edge, so their effect is checked one cycle later, with the next instruction. Merge penalties are measured by holding the read and counting the sampled cycles with `stall` high until it drops. Retire-wait holds are checked cycle by cycle, and the retire pulse is given in the last stalled cycle.

// File: rtl/prh_pkg.sv
package prh_pkg;

  typedef enum logic [2:0] {
    ACC_LO8 = 3'd0,
    ACC_HI8 = 3'd1,
    ACC_W16 = 3'd2,
    ACC_D32 = 3'd3,
    ACC_Q64 = 3'd4
  } accWidth_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic commit;      // presented instruction is accepted this cycle
    logic mergeClear;  // merge finishes: clear pending parts of the source reg
  } prhStrobes_t;

  // Byte regions touched: bit0 = bits 7:0, bit1 = bits 15:8, bit2 = above 15.
  function automatic logic [2:0] regionMask(input logic [2:0] w);
    case (w)
      ACC_LO8: regionMask = 3'b001;
      ACC_HI8: regionMask = 3'b010;
      ACC_W16: regionMask = 3'b011;
      default: regionMask = 3'b111;
    endcase
  endfunction

  function automatic logic isFull(input logic [2:0] w);
    isFull = (w != ACC_LO8) && (w != ACC_HI8) && (w != ACC_W16);
  endfunction

  // Pending-bit slot of a narrow write: 0 low byte, 1 high byte, 2 word.
  function automatic logic [1:0] partSlot(input logic [2:0] w);
    case (w)
      ACC_LO8: partSlot = 2'd0;
      ACC_HI8: partSlot = 2'd1;
      default: partSlot = 2'd2;
    endcase
  endfunction

  function automatic logic [2:0] slotMask(input int k);
    case (k)
      0:       slotMask = 3'b001;
      1:       slotMask = 3'b010;
      default: slotMask = 3'b011;
    endcase
  endfunction

endpackage

// File: rtl/prh_datapath.sv
module prh_datapath
  import prh_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dstEn,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [2:0]       dstWidth,
  input  logic             zeroIdiom,
  input  logic             srcEn,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [2:0]       srcWidth,
  input  logic             retireValid,
  input  logic [IDX_W-1:0] retireIdx,
  input  prhStrobes_t      strobes,
  output logic             hazard,
  output logic             hazardHi
);

  localparam int PARTS = 3;

  logic [PARTS-1:0]    pend [NUM_REGS];
  logic [NUM_REGS-1:0] knownClr;

  logic [2:0]       readMask;
  logic [PARTS-1:0] srcPend;
  logic [PARTS-1:0] partHaz;
  logic             srcClear;

  assign readMask = regionMask(srcWidth);
  assign srcPend  = pend[srcIdx];
  assign srcClear = knownClr[srcIdx];

  // A pending part conflicts when the read overlaps it yet reaches outside it.
  for (genvar k = 0; k < PARTS; k++) begin : gPart
    localparam logic [2:0] PM = slotMask(k);
    assign partHaz[k] = srcPend[k] && |(readMask & PM) && |(readMask & ~PM);
  end

  assign hazard   = srcEn && |partHaz && !srcClear;
  assign hazardHi = srcEn && partHaz[1] && !srcClear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) pend[i] <= '0;
      knownClr <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (retireValid && retireIdx == IDX_W'(i)) pend[i] <= '0;
        if (strobes.mergeClear && srcIdx == IDX_W'(i)) pend[i] <= '0;
        if (strobes.commit && dstEn && dstIdx == IDX_W'(i)) begin
          if (isFull(dstWidth)) begin
            pend[i]     <= '0;
            knownClr[i] <= zeroIdiom;
          end else begin
            pend[i][partSlot(dstWidth)] <= 1'b1;
          end
        end
      end
    end
  end

  assert_full_write_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit && dstEn && isFull(dstWidth) |=> pend[$past(dstIdx)] == '0);

  assert_retire_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    retireValid && !(strobes.commit && dstEn && dstIdx == retireIdx)
      |=> pend[$past(retireIdx)] == '0);

  assert_idiom_marks_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit && dstEn && zeroIdiom && isFull(dstWidth) |=> knownClr[$past(dstIdx)]);

  assert_merge_resolves_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mergeClear && !(strobes.commit && dstEn) |=> pend[$past(srcIdx)] == '0);

endmodule

// File: rtl/prh_control.sv
module prh_control
  import prh_pkg::*;
#(
  parameter int MERGE_CYCLES = 2,
  parameter int HIGH_EXTRA   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mergeMode,
  input  logic        instValid,
  input  logic        hazard,
  input  logic        hazardHi,
  output logic        stall,
  output prhStrobes_t strobes
);

  localparam int LO_EFF = (MERGE_CYCLES < 2) ? 2 : MERGE_CYCLES;
  localparam int HI_TOT = LO_EFF + HIGH_EXTRA;
  localparam int CNT_W  = $clog2(HI_TOT + 1);

  logic [CNT_W-1:0] mergeLeft;
  logic             mergeBusy;

  assign mergeBusy          = (mergeLeft != '0);
  assign stall              = instValid && (mergeBusy || hazard);
  assign strobes.commit     = instValid && !stall;
  assign strobes.mergeClear = (mergeLeft == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mergeLeft <= '0;
    end else if (mergeBusy) begin
      mergeLeft <= mergeLeft - CNT_W'(1);
    end else if (instValid && hazard && mergeMode) begin
      mergeLeft <= hazardHi ? CNT_W'(HI_TOT - 1) : CNT_W'(LO_EFF - 1);
    end
  end

  assert_merge_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    mergeLeft <= CNT_W'(HI_TOT - 1));

endmodule

// File: rtl/partial_reg_stall.sv
module partial_reg_stall
  import prh_pkg::*;
#(
  parameter int NUM_REGS     = 16,
  parameter int MERGE_CYCLES = 2,
  parameter int HIGH_EXTRA   = 1,
  parameter int IDX_W        = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mergeMode,
  input  logic             dstEn,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [2:0]       dstWidth,
  input  logic             zeroIdiom,
  input  logic             srcEn,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [2:0]       srcWidth,
  input  logic             retireValid,
  input  logic [IDX_W-1:0] retireIdx,
  output logic             stall
);

  prhStrobes_t strobes;
  logic        hazard;
  logic        hazardHi;

  prh_datapath #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN),
    .dstEn(dstEn), .dstIdx(dstIdx), .dstWidth(dstWidth), .zeroIdiom(zeroIdiom),
    .srcEn(srcEn), .srcIdx(srcIdx), .srcWidth(srcWidth),
    .retireValid(retireValid), .retireIdx(retireIdx),
    .strobes(strobes), .hazard(hazard), .hazardHi(hazardHi)
  );

  prh_control #(.MERGE_CYCLES(MERGE_CYCLES), .HIGH_EXTRA(HIGH_EXTRA)) uCtrl (
    .clk(clk), .rstN(rstN), .mergeMode(mergeMode),
    .instValid(dstEn || srcEn), .hazard(hazard), .hazardHi(hazardHi),
    .stall(stall), .strobes(strobes)
  );

  // Upstream contract: a stalled instruction is presented again unchanged.
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(srcIdx) && $stable(srcWidth) && $stable(dstIdx) && $stable(dstWidth));

endmodule

// File: tb/sim_partial_reg_stall.sv
module sim_partial_reg_stall;

  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic             mergeMode;
  logic             dstEn;
  logic [IDX_W-1:0] dstIdx;
  logic [2:0]       dstWidth;
  logic             zeroIdiom;
  logic             srcEn;
  logic [IDX_W-1:0] srcIdx;
  logic [2:0]       srcWidth;
  logic             retireValid;
  logic [IDX_W-1:0] retireIdx;
  logic             stall;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  partial_reg_stall u0 (
    .clk(clk), .rstN(rstN), .mergeMode(mergeMode),
    .dstEn(dstEn), .dstIdx(dstIdx), .dstWidth(dstWidth), .zeroIdiom(zeroIdiom),
    .srcEn(srcEn), .srcIdx(srcIdx), .srcWidth(srcWidth),
    .retireValid(retireValid), .retireIdx(retireIdx), .stall(stall)
  );

  // Row: {reg[3:0], idiomFirst, writeWidth[2:0], readWidth[2:0], expStall}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {4'd1,  1'b0, 3'd0, 3'd0, 1'b0},  // R3 low read after low write
    {4'd2,  1'b0, 3'd0, 3'd2, 1'b1},  // R2 word read after low write
    {4'd3,  1'b0, 3'd0, 3'd3, 1'b1},  // R2 dword read after low write
    {4'd4,  1'b0, 3'd0, 3'd1, 1'b0},  // R3 high read after low write
    {4'd5,  1'b0, 3'd1, 3'd2, 1'b1},  // R2 word read after high write
    {4'd6,  1'b0, 3'd1, 3'd0, 1'b0},  // R3 low read after high write
    {4'd7,  1'b0, 3'd2, 3'd0, 1'b0},  // R3 low read after word write
    {4'd8,  1'b0, 3'd2, 3'd1, 1'b0},  // R3 high read after word write
    {4'd9,  1'b0, 3'd2, 3'd4, 1'b1},  // R2 qword read after word write
    {4'd10, 1'b1, 3'd0, 3'd4, 1'b0},  // R5 zeroed then low write
    {4'd11, 1'b1, 3'd1, 3'd3, 1'b0},  // R5 zeroed then high write
    {4'd12, 1'b0, 3'd1, 3'd1, 1'b0}   // R3 high read after high write
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: stall=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkN(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: stall cycles=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle's inputs at the falling edge, then let them settle.
  task automatic drive(input logic de, input logic [3:0] di, input logic [2:0] dw,
                       input logic z, input logic se, input logic [3:0] si,
                       input logic [2:0] sw, input logic rv, input logic [3:0] ri);
    @(negedge clk);
    dstEn = de; dstIdx = di; dstWidth = dw; zeroIdiom = z;
    srcEn = se; srcIdx = si; srcWidth = sw;
    retireValid = rv; retireIdx = ri;
    #2;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [3:0] r, input logic [2:0] w, input logic z);
    drive(1, r, w, z, 0, 0, 0, 0, 0);
  endtask

  // Hold a read until stall drops; return the number of stalled cycles.
  task automatic countStall(input logic [3:0] r, input logic [2:0] w, output int n);
    n = 0;
    drive(0, 0, 0, 0, 1, r, w, 0, 0);
    for (int k = 0; k < 20; k++) begin
      if (!stall) break;
      n++;
      @(negedge clk);
      #2;
    end
    idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rstN = 1'b0; mergeMode = 1'b0;
    dstEn = 0; dstIdx = 0; dstWidth = 0; zeroIdiom = 0;
    srcEn = 0; srcIdx = 0; srcWidth = 0; retireValid = 0; retireIdx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    idle();
    check("R1 idle", stall, 1'b0);
    for (int r = 0; r < 16; r++) begin
      drive(0, 0, 0, 0, 1, 4'(r), 3'd4, 0, 0);
      check("R1 qword read", stall, 1'b0);
    end
    idle();

    // Table: write, then read with retire in the same cycle, then re-read
    for (int i = 0; i < NV; i++) begin
      logic [3:0] r;
      logic       idi;
      logic [2:0] ww, rw;
      logic       ex;
      {r, idi, ww, rw, ex} = VEC[i];
      if (idi) wr(r, 3'd4, 1'b1);
      wr(r, ww, 1'b0);
      drive(0, 0, 0, 0, 1, r, rw, 1, r);
      check($sformatf("R2/R3/R5 row %0d", i), stall, ex);
      drive(0, 0, 0, 0, 1, r, rw, 0, 0);
      check($sformatf("R4 after retire row %0d", i), stall, 1'b0);
      idle();
    end

    // R4: stall persists, foreign retire ignored, own retire releases
    wr(4'd13, 3'd0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      drive(0, 0, 0, 0, 1, 4'd13, 3'd3, 1, 4'd14);
      check("R4 hold with other retire", stall, 1'b1);
    end
    drive(0, 0, 0, 0, 1, 4'd13, 3'd3, 1, 4'd13);
    check("R4 retire cycle", stall, 1'b1);
    drive(0, 0, 0, 0, 1, 4'd13, 3'd3, 0, 0);
    check("R4 released", stall, 1'b0);
    idle();

    // R6: plain full write cancels known-clear
    wr(4'd14, 3'd3, 1'b1);
    wr(4'd14, 3'd3, 1'b0);
    wr(4'd14, 3'd0, 1'b0);
    drive(0, 0, 0, 0, 1, 4'd14, 3'd4, 1, 4'd14);
    check("R6 hazard after plain full write", stall, 1'b1);
    drive(0, 0, 0, 0, 1, 4'd14, 3'd4, 0, 0);
    check("R6 released", stall, 1'b0);
    idle();

    // R5: zeroIdiom on a narrow write does not mark clear
    wr(4'd15, 3'd0, 1'b1);
    drive(0, 0, 0, 0, 1, 4'd15, 3'd4, 1, 4'd15);
    check("R5 narrow idiom ignored", stall, 1'b1);
    drive(0, 0, 0, 0, 1, 4'd15, 3'd4, 0, 0);
    idle();

    // R7: full write clears pending parts
    wr(4'd15, 3'd0, 1'b0);
    wr(4'd15, 3'd1, 1'b0);
    wr(4'd15, 3'd3, 1'b0);
    drive(0, 0, 0, 0, 1, 4'd15, 3'd4, 0, 0);
    check("R7 cleared by full write", stall, 1'b0);
    idle();

    // Merge mode
    mergeMode = 1'b1;
    wr(4'd1, 3'd0, 1'b0);
    countStall(4'd1, 3'd2, n);
    checkN("R8 low-byte merge", n, 2);
    drive(0, 0, 0, 0, 1, 4'd1, 3'd4, 0, 0);
    check("R8 merged register", stall, 1'b0);
    idle();
    wr(4'd2, 3'd2, 1'b0);
    countStall(4'd2, 3'd3, n);
    checkN("R8 word merge", n, 2);
    countStall(4'd2, 3'd4, n);
    checkN("R8 no hazard no merge", n, 0);
    wr(4'd3, 3'd1, 1'b0);
    countStall(4'd3, 3'd4, n);
    checkN("R9 high-byte merge", n, 3);
    wr(4'd4, 3'd0, 1'b0);
    wr(4'd4, 3'd1, 1'b0);
    countStall(4'd4, 3'd2, n);
    checkN("R9 low and high pending", n, 3);
    wr(4'd5, 3'd1, 1'b0);
    countStall(4'd5, 3'd0, n);
    checkN("R3 disjoint in merge mode", n, 0);
    idle();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule